// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a DDR SDRAM device from reset until the memory is ready for normal traffic. Once reset is released it keeps the clock-enable line low with only NOPs on the bus for a programmable power-settle period. It then raises clock enable with one NOP and issues the fixed start-up series. That series closes all banks, loads the extended mode register to enable the DLL, and loads the mode register with the DLL-reset bit set. It then closes all banks again, runs two auto refreshes and reloads the mode register with the DLL-reset bit cleared. Each command is followed by its own wait, given in clock cycles.

The burst and latency bits of the mode register and the whole extended mode register word come in on input ports. They must be held stable while the series runs. A completion flag rises only after two things: the last mode load has had its settle time, and at least the DLL lock count has passed since the DLL-reset load. The flag then stays high until the next reset. A reset at any point starts the whole series again from the clock-enable-low wait.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `cke` is 0, the bus carries NOP (`cs_n,ras_n,cas_n,we_n` = 0,1,1,1) and `init_done` is 0. A reset in the middle of the series restarts it from the start.
- R2: After reset release, `cke` stays 0 for exactly `T_PWR` clock cycles, with NOP on the bus during all of them.
- R3: Clock enable then rises together with a single NOP cycle, and `cke` stays 1 from then on.
- R4: Seven commands follow, in a fixed order: precharge-all, extended mode load, DLL-reset mode load, precharge-all, auto refresh, auto refresh, normal mode load.
- R5: The command codes on `cs_n,ras_n,cas_n,we_n` are: precharge 0,0,1,0; auto refresh 0,0,0,1; mode load 0,0,0,0. Every cycle that carries no command carries NOP, and the bus never carries a deselect.
- R6: A precharge-all drives `addr[10]`=1, all other address bits 0 and `ba`=00.
- R7: The extended mode load drives `ba`=01 (bank bit 0 high) and `addr` equal to `ext_mode`.
- R8: Both mode-register loads drive `ba`=00 and `addr[6:0]`=`mode_bits`. The first load has `addr[11:7]`=00010, which sets the DLL-reset bit `addr[8]`. The final load has `addr[11:7]`=00000.
- R9: The gap from one command to the next is exactly `T_RP` after a precharge, `T_MRD` after a mode load and `T_RFC` after an auto refresh. The gap from the clock-enable NOP to the first precharge is one cycle.
- R10: `init_done` rises at cycle max(D+`T_DLL`+1, F+`T_MRD`), where D and F are the cycles of the DLL-reset load and of the final mode load. It therefore never rises within `T_DLL` cycles of the DLL reset.
- R11: Once `init_done` is 1, it stays 1 until reset, with `cke`=1 and NOP on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the series |
| mode_bits | input | 7 | Burst length, burst type and CAS latency field of the mode register |
| ext_mode | input | 12 | Full word for the extended mode register load |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / mode register select |
| addr | output | 12 | Address / op-code bus |
| init_done | output | 1 | High once the memory may take normal commands |

## Verification
A step register that skips or repeats a state puts a wrong or out-of-order command on the bus. That shows at the ports within one command gap. A gap counter that is loaded wrongly moves every later command and the `init_done` edge, and the error is visible at the very next command. A fault in the DLL lock counter shows only at the `init_done` edge, because it has no effect on the bus itself; that edge is therefore compared against an exact expected cycle. Random op-codes across repeated runs, together with resets placed in the power wait and in the refresh stage, confirm that the op-code fields land in the right places and that restart state is clean.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // Sequence steps in issue order
  typedef enum logic [3:0] {
    ST_PWR,     // hold clock enable low
    ST_CKE,     // raise clock enable with a NOP
    ST_PRE_A,   // first precharge-all
    ST_EMR,     // extended mode load (DLL enable)
    ST_MR_DLL,  // mode load with DLL reset
    ST_PRE_B,   // second precharge-all
    ST_REF_A,   // first auto refresh
    ST_REF_B,   // second auto refresh
    ST_MR_RUN,  // mode load, DLL reset cleared
    ST_WAIT,    // wait for DLL lock count
    ST_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  function automatic step_e step_after(step_e s);
    case (s)
      ST_PWR:    return ST_CKE;
      ST_CKE:    return ST_PRE_A;
      ST_PRE_A:  return ST_EMR;
      ST_EMR:    return ST_MR_DLL;
      ST_MR_DLL: return ST_PRE_B;
      ST_PRE_B:  return ST_REF_A;
      ST_REF_A:  return ST_REF_B;
      ST_REF_B:  return ST_MR_RUN;
      ST_MR_RUN: return ST_WAIT;
      default:   return ST_DONE;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R9: an idle timer never wraps into a new wait on its own
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/ddr_init_cmd_gen.sv
module ddr_init_cmd_gen
  import ddr_init_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int BA_W     = 2,
  parameter int MODE_W   = 7,
  parameter int GAP_W    = 16,
  parameter int T_PWR    = 25000,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 10,
  parameter int DLL_BIT  = 8,
  parameter int ALL_BIT  = 10
) (
  input  step_e              step,
  input  logic [MODE_W-1:0]  mode_bits,
  input  logic [ROW_W-1:0]   ext_mode,
  output cmd_e               cmd,
  output logic               cke_val,
  output logic [BA_W-1:0]    ba,
  output logic [ROW_W-1:0]   addr,
  output logic [GAP_W-1:0]   gap
);
  always_comb begin
    cmd     = CMD_NOP;
    cke_val = 1'b1;
    ba      = '0;
    addr    = '0;
    gap     = GAP_W'(1);
    case (step)
      ST_PWR: begin
        cke_val = 1'b0;
        gap     = GAP_W'(T_PWR);
      end
      ST_PRE_A, ST_PRE_B: begin
        cmd           = CMD_PRE;
        addr[ALL_BIT] = 1'b1;
        gap           = GAP_W'(T_RP);
      end
      ST_EMR: begin
        cmd  = CMD_LMR;
        ba   = BA_W'(1);
        addr = ext_mode;
        gap  = GAP_W'(T_MRD);
      end
      ST_MR_DLL: begin
        cmd                = CMD_LMR;
        addr[MODE_W-1:0]   = mode_bits;
        addr[DLL_BIT]      = 1'b1;
        gap                = GAP_W'(T_MRD);
      end
      ST_REF_A, ST_REF_B: begin
        cmd = CMD_REF;
        gap = GAP_W'(T_RFC);
      end
      ST_MR_RUN: begin
        cmd              = CMD_LMR;
        addr[MODE_W-1:0] = mode_bits;
        gap              = GAP_W'(T_MRD);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BA_W   = 2,
  parameter int MODE_W = 7,
  parameter int T_PWR  = 25000,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 10,
  parameter int T_DLL  = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_bits,
  input  logic [ROW_W-1:0]  ext_mode,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ROW_W-1:0]  addr,
  output logic              init_done
);
  localparam int DLL_BIT = 8;
  localparam int ALL_BIT = 10;
  localparam int GAP_MAX = (T_PWR > T_RFC) ?
                           ((T_PWR > T_RP) ? ((T_PWR > T_MRD) ? T_PWR : T_MRD) : T_RP) :
                           ((T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD) : T_RP);
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int DLL_W   = $clog2(T_DLL + 1);

  step_e              step;
  cmd_e               cmd_q;
  logic               cke_q;
  logic [BA_W-1:0]    ba_q;
  logic [ROW_W-1:0]   addr_q;
  logic               done_q;

  cmd_e               g_cmd;
  logic               g_cke;
  logic [BA_W-1:0]    g_ba;
  logic [ROW_W-1:0]   g_addr;
  logic [GAP_W-1:0]   g_gap;

  logic               gap_zero;
  logic               dll_zero;
  logic               issue;

  ddr_init_cmd_gen #(
    .ROW_W(ROW_W), .BA_W(BA_W), .MODE_W(MODE_W), .GAP_W(GAP_W),
    .T_PWR(T_PWR), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .DLL_BIT(DLL_BIT), .ALL_BIT(ALL_BIT)
  ) u_gen (
    .step(step), .mode_bits(mode_bits), .ext_mode(ext_mode),
    .cmd(g_cmd), .cke_val(g_cke), .ba(g_ba), .addr(g_addr), .gap(g_gap)
  );

  assign issue = gap_zero && (step != ST_WAIT) && (step != ST_DONE);

  ddr_init_timer #(.W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .load(issue),
    .load_val(g_gap - GAP_W'(1)), .zero(gap_zero)
  );

  ddr_init_timer #(.W(DLL_W)) u_dll (
    .clk(clk), .rst(rst), .load(issue && (step == ST_MR_DLL)),
    .load_val(DLL_W'(T_DLL)), .zero(dll_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= ST_PWR;
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b0;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (issue) begin
        cmd_q  <= g_cmd;
        cke_q  <= g_cke;
        ba_q   <= g_ba;
        addr_q <= g_addr;
        step   <= step_after(step);
      end else if (step == ST_WAIT && gap_zero && dll_zero) begin
        done_q <= 1'b1;
        step   <= ST_DONE;
      end
    end
  end

  assign cke       = cke_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign init_done = done_q;

  // Age of the DLL-reset load as seen on the bus (checker counter)
  logic             dll_seen;
  logic [DLL_W:0]   dll_age;
  always_ff @(posedge clk) begin
    if (rst) begin
      dll_seen <= 1'b0;
      dll_age  <= '0;
    end else if (cmd_q == CMD_LMR && ba_q == '0 && addr_q[DLL_BIT]) begin
      dll_seen <= 1'b1;
      dll_age  <= (DLL_W+1)'(1);
    end else if (dll_seen && dll_age <= (DLL_W+1)'(T_DLL)) begin
      dll_age  <= dll_age + (DLL_W+1)'(1);
    end
  end

  // R2: with clock enable low only NOP appears
  a_r2_cke_low_nop: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd_q == CMD_NOP));
  // R9: while a wait runs the next bus cycle is a NOP
  a_r9_gap_nop: assert property (@(posedge clk) disable iff (rst)
    !gap_zero |=> (cmd_q == CMD_NOP));
  // R6: a precharge is always the all-banks form
  a_r6_pre_all: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> addr_q[ALL_BIT]);
  // R10: completion only after the DLL lock count
  a_r10_dll_lock: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (dll_seen && dll_age > (DLL_W+1)'(T_DLL)));
  // R11: completion is sticky with a quiet, enabled bus
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && cmd_q == CMD_NOP));
  // R3: clock enable never drops once raised
  a_r3_cke_hold: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;
  localparam int T_PWR = 40;
  localparam int T_RP  = 3;
  localparam int T_MRD = 2;
  localparam int T_RFC = 9;
  localparam int T_DLL = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  mode_bits = '0;
  logic [11:0] ext_mode = '0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [11:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .T_PWR(T_PWR), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLL(T_DLL)
  ) u_ddr_init_seq (
    .clk(clk), .rst(rst), .mode_bits(mode_bits), .ext_mode(ext_mode),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int k);
    case (k)
      0, 3:    return 4'b0010;
      4, 5:    return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [11:0] exp_addr(input int k, input logic [11:0] e,
                                           input logic [6:0] m);
    case (k)
      0, 3:    return 12'h400;
      1:       return e;
      2:       return 12'h100 | {5'b0, m};
      default: return {5'b0, m};
    endcase
  endfunction

  function automatic int exp_gap(input int k);
    case (k)
      0:       return 1;
      1, 4:    return T_RP;
      2, 3:    return T_MRD;
      default: return T_RFC;
    endcase
  endfunction

  task automatic reset_check(input string tag);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(cke == 1'b0 && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && init_done == 1'b0,
        "R1", tag, {cke, cs_n, ras_n, cas_n, we_n, init_done}, 6'b001110);
  endtask

  task automatic run_seq(input logic [11:0] e, input logic [6:0] m);
    int cyc = 0, low_cnt = 0, hi_idx = -1, ncmd = 0, done_idx = -1;
    int prev_idx = 0, bad_idle = 0, bad_cke = 0, sticky = 0;
    int idx[7];
    ext_mode  = e;
    mode_bits = m;
    reset_check("reset state");
    rst = 1'b0;
    @(negedge clk);
    cyc = 1;
    chk(cke == 1'b0 && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1",
        "first cycle after reset", {cke, cs_n, ras_n, cas_n, we_n}, 5'b00111);
    while (sticky < 30 && cyc < 3000) begin
      if (hi_idx < 0) begin
        if (!cke) begin
          low_cnt++;
          if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) bad_idle++;
        end else begin
          hi_idx = cyc;
          prev_idx = cyc;
          chk(low_cnt == T_PWR, "R2", "clock enable low cycles", low_cnt, T_PWR);
          chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R3", "NOP with clock enable",
              {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        end
      end else begin
        if (!cke) bad_cke++;
        if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
          if (ncmd < 7) begin
            idx[ncmd] = cyc;
            chk({cs_n, ras_n, cas_n, we_n} == exp_code(ncmd), "R4 R5", "command code",
                {cs_n, ras_n, cas_n, we_n}, exp_code(ncmd));
            chk(cyc - prev_idx == exp_gap(ncmd), "R9", "command gap",
                cyc - prev_idx, exp_gap(ncmd));
            if (ncmd != 4 && ncmd != 5) begin
              chk(ba == ((ncmd == 1) ? 2'b01 : 2'b00), "R6 R7 R8", "bank bits",
                  ba, (ncmd == 1) ? 2'b01 : 2'b00);
              chk(addr == exp_addr(ncmd, e, m), "R6 R7 R8", "address bits",
                  addr, exp_addr(ncmd, e, m));
            end
            prev_idx = cyc;
          end else begin
            bad_idle++;
          end
          ncmd++;
        end
        if (init_done && done_idx < 0) begin
          int a, b, x;
          done_idx = cyc;
          a = idx[2] + T_DLL + 1;
          b = idx[6] + T_MRD;
          x = (a > b) ? a : b;
          chk(ncmd == 7, "R4", "commands before completion", ncmd, 7);
          chk(done_idx == x, "R10", "completion cycle", done_idx, x);
        end
        if (done_idx >= 0) begin
          if (!init_done) bad_cke++;
          sticky++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 3000, "R10", "completion seen before watchdog", cyc, 3000);
    chk(bad_idle == 0, "R5", "non-NOP idle or extra command cycles", bad_idle, 0);
    chk(bad_cke == 0, "R11", "clock enable or completion dropped", bad_cke, 0);
  endtask

  task automatic abort_seq(input int n, input string tag);
    rst = 1'b0;
    repeat (n) @(negedge clk);
    reset_check(tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    // Directed: all op-code bits set, then all clear
    run_seq(12'hFFF, 7'h7F);
    run_seq(12'h000, 7'h00);
    // R1: reset during the clock-enable-low wait and during refresh
    abort_seq(T_PWR / 2, "reset during power wait");
    run_seq(12'($urandom), 7'($urandom));
    abort_seq(T_PWR + 1 + T_RP + 2 * T_MRD + T_RP + 3, "reset during refresh");
    // Random op-codes across further runs
    for (int r = 0; r < 3; r++) run_seq(12'($urandom), 7'($urandom));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule